// File: doc/BRIEF.md
# Dual Programmable Clock Ratio Divider

This block runs on a fast reference clock and produces two single-cycle enable streams in that same clock domain: a core-rate enable and a system-rate enable. Each stream comes from its own divider, and both dividers count the reference clock directly. Neither divider is chained to the other. The core divider uses a power-of-two ratio chosen by a 2-bit code. The system divider uses a linear ratio from 1 to 15.

Software sets both ratios through one divisor register, using a simple synchronous write port. It may rewrite the register at any time while the block runs. A new ratio waits until the divider finishes its current period, so no enable period is ever cut short or doubled. A read port returns the ratios currently in effect, a sticky error flag, and the result of comparing the active system ratio against a programmable minimum. That minimum keeps the system rate below its allowed maximum.

Top module: `clk_ratio_div`

## Requirements
- R1: After reset, `sysTick` and `coreTick` are both high on every reference cycle, the divisor read shows system ratio 1 and core code 00, and `errFlag` is 0.
- R2: The system field of the divisor register is at address 0, bits [3:0]. A value N from 1 to 15 spaces `sysTick` pulses exactly N reference cycles apart.
- R3: The core field of the divisor register is at address 0, bits [5:4]. Codes 00, 01, 10 and 11 space `coreTick` pulses 1, 2, 4 and 8 reference cycles apart.
- R4: A newly written ratio takes effect only at the divider's next pulse. The period already in progress keeps its old length, and the period after it uses the new ratio.
- R5: Reading address 0 returns the ratios in effect: bits [3:0] hold the active system ratio and bits [5:4] hold the active core code. A pending value does not appear until it is applied.
- R6: If a divisor write carries system field 0000, the system ratio is left unchanged. The core field of that same write is still accepted, and the sticky error bit (address 1, bit 0, also driven on `errFlag`) is set.
- R7: Writing 1 to address 1, bit 0 clears the sticky error bit. Writing 0 to that bit leaves it unchanged.
- R8: The limit register is at address 2, bits [3:0], and resets to 1. `overLimit` (also readable at address 1, bit 1) is high exactly when the active system ratio is smaller than the limit. An equal value is allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 6 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 6 | Read data (combinational) |
| coreTick | output | 1 | Core-rate enable pulse |
| sysTick | output | 1 | System-rate enable pulse |
| errFlag | output | 1 | Sticky illegal-setting flag |
| overLimit | output | 1 | Active system ratio is below the limit |

## Verification
The assertions assume that the bus issues at most one write per cycle. They also assume that writes to the status address and to the divisor address never occur in the same cycle, and that inputs settle before each rising edge. The bench meets these assumptions by driving every input on the falling edge, through one write task that holds `wrEn` for exactly one cycle. Pulse spacing is measured with a cycle counter that is sampled on falling edges. Mid-period changes are timed from a known pulse, so every write falls strictly inside a divide period.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int SYS_W   = 4;
  localparam int CORE_CW = 2;
  localparam int CORE_RW = 2 ** CORE_CW;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = SYS_W + CORE_CW;

  localparam logic [ADDR_W-1:0] ADDR_DIV   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LIMIT = 2'd2;

  // Pending ratios handed from control to datapath
  typedef struct packed {
    logic [SYS_W-1:0]   sysRatio;
    logic [CORE_RW-1:0] coreRatio;
  } ratio_cfg_t;

  function automatic logic [CORE_RW-1:0] coreDecode(input logic [CORE_CW-1:0] code);
    logic [CORE_RW-1:0] one;
    one = {{(CORE_RW-1){1'b0}}, 1'b1};
    return one << code;
  endfunction

  function automatic logic [CORE_CW-1:0] coreEncode(input logic [CORE_RW-1:0] ratio);
    logic [CORE_CW-1:0] enc;
    enc = '0;
    for (int i = 0; i < CORE_RW; i++) begin
      if (ratio == coreDecode(CORE_CW'(i))) enc = CORE_CW'(i);
    end
    return enc;
  endfunction
endpackage

// File: rtl/ratio_div.sv
module ratio_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] nextRatio,
  output logic         tick,
  output logic [W-1:0] activeRatio
);
  logic [W-1:0] cnt;
  logic [W-1:0] sinceLast;

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= '0;
      activeRatio <= W'(1);
    end else if (tick) begin
      cnt         <= nextRatio - W'(1);
      activeRatio <= nextRatio;
    end else begin
      cnt <= cnt - W'(1);
    end
  end

  // Cycles elapsed since the previous pulse, kept for the spacing check
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     sinceLast <= W'(1);
    else if (tick) sinceLast <= W'(1);
    else           sinceLast <= sinceLast + W'(1);
  end

  AST_GAP_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> sinceLast == activeRatio); // R2, R3

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(activeRatio)); // R4
endmodule

// File: rtl/ratio_datapath.sv
module ratio_datapath
  import clk_ratio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ratio_cfg_t         cfg,
  output logic               sysTick,
  output logic               coreTick,
  output logic [SYS_W-1:0]   activeSys,
  output logic [CORE_RW-1:0] activeCore
);
  ratio_div #(.W(SYS_W)) i_sysDiv (
    .clk         (clk),
    .rstN        (rstN),
    .nextRatio   (cfg.sysRatio),
    .tick        (sysTick),
    .activeRatio (activeSys)
  );

  ratio_div #(.W(CORE_RW)) i_coreDiv (
    .clk         (clk),
    .rstN        (rstN),
    .nextRatio   (cfg.coreRatio),
    .tick        (coreTick),
    .activeRatio (activeCore)
  );
endmodule

// File: rtl/ratio_ctrl.sv
module ratio_ctrl
  import clk_ratio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  input  logic [SYS_W-1:0]   activeSys,
  input  logic [CORE_RW-1:0] activeCore,
  output ratio_cfg_t         cfg,
  output logic               errSticky,
  output logic               overLimit
);
  logic [SYS_W-1:0]   pendSys;
  logic [CORE_CW-1:0] pendCore;
  logic [SYS_W-1:0]   limitReg;
  logic               divWrite;
  logic               sysZero;

  assign divWrite = wrEn && (wrAddr == ADDR_DIV);
  assign sysZero  = (wrData[SYS_W-1:0] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendSys   <= SYS_W'(1);
      pendCore  <= '0;
      limitReg  <= SYS_W'(1);
      errSticky <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_DIV: begin
          pendCore <= wrData[SYS_W +: CORE_CW];
          if (sysZero) errSticky <= 1'b1;
          else         pendSys   <= wrData[SYS_W-1:0];
        end
        ADDR_STAT:  if (wrData[0]) errSticky <= 1'b0;
        ADDR_LIMIT: limitReg <= wrData[SYS_W-1:0];
        default: ;
      endcase
    end
  end

  assign cfg.sysRatio  = pendSys;
  assign cfg.coreRatio = coreDecode(pendCore);
  assign overLimit     = (activeSys < limitReg);

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_DIV: begin
        rdData[SYS_W-1:0]       = activeSys;
        rdData[SYS_W +: CORE_CW] = coreEncode(activeCore);
      end
      ADDR_STAT: begin
        rdData[0] = errSticky;
        rdData[1] = overLimit;
      end
      ADDR_LIMIT: rdData[SYS_W-1:0] = limitReg;
      default: ;
    endcase
  end

  AST_ZERO_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    divWrite && sysZero |=> errSticky && $stable(pendSys)); // R6

  AST_PEND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    pendSys != '0); // R6

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrAddr == ADDR_STAT && wrData[0] |=> !errSticky); // R7
endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div
  import clk_ratio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              coreTick,
  output logic              sysTick,
  output logic              errFlag,
  output logic              overLimit
);
  ratio_cfg_t         cfg;
  logic [SYS_W-1:0]   activeSys;
  logic [CORE_RW-1:0] activeCore;

  ratio_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .activeSys  (activeSys),
    .activeCore (activeCore),
    .cfg        (cfg),
    .errSticky  (errFlag),
    .overLimit  (overLimit)
  );

  ratio_datapath i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfg        (cfg),
    .sysTick    (sysTick),
    .coreTick   (coreTick),
    .activeSys  (activeSys),
    .activeCore (activeCore)
  );
endmodule

// File: tb/test_clk_ratio_div.sv
`timescale 1ns/1ps
module test_clk_ratio_div;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [5:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [5:0] rdData;
  logic       coreTick, sysTick, errFlag, overLimit;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  localparam int NVEC = 15;
  localparam int VEC_SYS [NVEC]  = '{1, 3, 10, 2, 15, 4, 5, 6, 7, 8, 9, 11, 12, 13, 14};
  localparam int VEC_CORE[NVEC]  = '{0, 1, 2, 3, 3, 2, 1, 0, 1, 3, 0, 2, 2, 1, 3};
  localparam int EXP_CORE[NVEC]  = '{1, 2, 4, 8, 8, 4, 2, 1, 2, 8, 1, 4, 4, 2, 8};

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clk_ratio_div i_clk_ratio_div (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .coreTick(coreTick), .sysTick(sysTick),
    .errFlag(errFlag), .overLimit(overLimit)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [5:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitSys(output int t);
    @(negedge clk);
    while (!sysTick) @(negedge clk);
    t = cyc;
  endtask

  task automatic waitCore(output int t);
    @(negedge clk);
    while (!coreTick) @(negedge clk);
    t = cyc;
  endtask

  task automatic sysGap(output int g);
    int t1, t2;
    waitSys(t1);
    waitSys(t2);
    g = t2 - t1;
  endtask

  task automatic coreGap(output int g);
    int t1, t2;
    waitCore(t1);
    waitCore(t2);
    g = t2 - t1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    wait (cyc > 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finishRun();
  end

  initial begin
    logic [5:0] rd;
    int g, t0, t1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 sysTick every cycle", sysTick, 1);
      check("R1 coreTick every cycle", coreTick, 1);
    end
    regRead(2'd0, rd);
    check("R1 divisor read after reset", rd, 6'h01);
    check("R1 errFlag after reset", errFlag, 0);

    // Table walk: R2 R3 R5
    for (int i = 0; i < NVEC; i++) begin
      regWrite(2'd0, 6'((VEC_CORE[i] << 4) | VEC_SYS[i]));
      sysGap(g);
      check("R2 system pulse spacing", g, VEC_SYS[i]);
      coreGap(g);
      check("R3 core pulse spacing", g, EXP_CORE[i]);
      regRead(2'd0, rd);
      check("R5 active ratio readback", rd, (VEC_CORE[i] << 4) | VEC_SYS[i]);
    end

    // R4 mid-period system change 10 -> 3
    regWrite(2'd0, 6'h3A);
    sysGap(g); coreGap(g);
    waitSys(t0);
    repeat (3) @(negedge clk);
    regWrite(2'd0, 6'h33);
    regRead(2'd0, rd);
    check("R5 pending not visible", rd, 6'h3A);
    waitSys(t1);
    check("R4 period in progress kept", t1 - t0, 10);
    waitSys(t0);
    check("R4 new system ratio after boundary", t0 - t1, 3);

    // R4 mid-period core change 8 -> 1
    waitCore(t0);
    repeat (2) @(negedge clk);
    regWrite(2'd0, 6'h03);
    waitCore(t1);
    check("R4 core period in progress kept", t1 - t0, 8);
    waitCore(t0);
    check("R4 new core ratio after boundary", t0 - t1, 1);

    // R6 illegal system field
    regWrite(2'd0, 6'h10);
    check("R6 error set on zero field", errFlag, 1);
    sysGap(g);
    check("R6 system ratio kept", g, 3);
    coreGap(g);
    check("R6 core field still applied", g, 2);
    regRead(2'd1, rd);
    check("R6 status error bit", rd[0], 1);

    // R7 write-one-to-clear
    regWrite(2'd1, 6'h00);
    check("R7 writing 0 keeps error", errFlag, 1);
    regWrite(2'd1, 6'h01);
    check("R7 writing 1 clears error", errFlag, 0);

    // R8 limit compare
    check("R8 no violation at reset limit", overLimit, 0);
    regWrite(2'd2, 6'h04);
    check("R8 ratio 3 below limit 4", overLimit, 1);
    regRead(2'd1, rd);
    check("R8 status overLimit bit", rd[1], 1);
    regRead(2'd2, rd);
    check("R8 limit readback", rd, 4);
    regWrite(2'd0, 6'h04);
    sysGap(g);
    check("R8 equal ratio allowed", overLimit, 0);
    regWrite(2'd0, 6'h05);
    sysGap(g);
    check("R8 ratio above limit", overLimit, 0);
    regWrite(2'd0, 6'h02);
    sysGap(g);
    check("R8 ratio 2 below limit", overLimit, 1);

    finishRun();
  end
endmodule